// File: doc/BRIEF.md
# Dual-Buffer Page Transfer and Compare Engine

This block holds a main array of fixed-size pages and two page buffers of the same size. A one-cycle launch pulse carries an operation code, a buffer select and a page address. The block then runs one self-timed operation against the chosen buffer:

- **Transfer** copies the addressed page into the buffer.
- **Compare** checks that page against the buffer, byte by byte.
- **Auto rewrite** copies the page into the buffer and then programs the buffer back into the same page.

A status byte can be polled at any time. It carries a ready flag and the result of the last compare. Every phase has a fixed length, counted in clock cycles and set by a parameter. One byte moves or is compared per cycle, during the first `PAGE_BYTES` cycles of a phase.

A diagnostic read port shows any byte of either buffer, so the buffer contents can be observed. At reset the main array takes a fixed pattern. Some of its pages are identical, and some differ only in their last byte. This makes match and mismatch outcomes reachable without a write path from the host.

Top module: `page_xfer_engine`

## Requirements
- R1: After reset, `status_o` reads 8'h80 (bit 7 ready = 1, bit 6 compare flag = 0, bits 5:0 always 0), and every byte of both buffers reads 0.
- R2: After reset, main page p byte i holds `i[7:0]`, XOR 8'hA5 when p is odd, XOR 8'h01 more when p mod 4 = 3 and i = `PAGE_BYTES`-1. A transfer (`op_i` = 2'b00) copies all `PAGE_BYTES` bytes of the page into the buffer picked by `buf_sel_i` (0 or 1) and leaves the other buffer unchanged.
- R3: A transfer or compare accepted at a clock edge drives `status_o[7]` to 0 for exactly `XFER_CYC` cycles, starting right after that edge.
- R4: A compare (`op_i` = 2'b01) sets `status_o[6]` to 0 at completion when all `PAGE_BYTES` bytes of page and buffer match, and to 1 on any mismatch, including a mismatch in the last byte alone. Busy lasts `XFER_CYC` cycles even when the scan stops early.
- R5: `status_o[6]` changes only at the edge where a compare completes. It holds its old value while a compare is busy, while the block is idle, and across transfers and rewrites.
- R6: An auto rewrite (`op_i` = 2'b10) loads the selected buffer with the page and then programs the buffer back into that page. It holds `status_o[7]` at 0 for `XFER_CYC` + `PROG_CYC` cycles, and the page content is unchanged afterwards.
- R7: The page address is taken modulo `PAGES`.
- R8: A launch while busy is ignored, and a launch with `op_i` = 2'b11 is ignored: busy length, buffers and flag are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| launch_i | input | 1 | One-cycle operation start |
| op_i | input | 2 | 00 transfer, 01 compare, 10 auto rewrite, 11 none |
| buf_sel_i | input | 1 | Target buffer |
| page_i | input | 10 | Main page address |
| peek_sel_i | input | 1 | Buffer shown on peek_data_o |
| peek_idx_i | input | 9 | Byte index shown on peek_data_o |
| peek_data_o | output | 8 | Combinational buffer byte read |
| status_o | output | 8 | Bit 7 ready, bit 6 compare mismatch, bits 5:0 zero |

## Verification
An operation is accepted at the edge where `launch_i` is sampled high. The bench drives the launch on a falling edge and counts the falling edges on which bit 7 reads 0; that count must equal `XFER_CYC`, or `XFER_CYC` + `PROG_CYC` for a rewrite.

The compare flag is due on the same edge as the return of ready, so it is read on the first falling edge with ready high. It is also sampled partway through a busy window, to confirm that it still holds the previous result. Buffer contents are read through the peek port only while the block is idle, after every operation has completed.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

  typedef enum logic [1:0] {
    OP_XFER = 2'b00,
    OP_CMP  = 2'b01,
    OP_REWR = 2'b10,
    OP_NONE = 2'b11
  } pxe_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_CMP,
    ST_PROG
  } pxe_st_e;

  // power-on content of the main array
  function automatic logic [7:0] pxe_pattern(int unsigned pg, int unsigned ix,
                                             int unsigned pb);
    logic [7:0] v;
    v = 8'(ix);
    if (pg % 2 == 1) v = v ^ 8'hA5;
    if (pg % 4 == 3 && ix == pb - 1) v = v ^ 8'h01;
    return v;
  endfunction

endpackage

// File: rtl/pxe_seq.sv
module pxe_seq
  import pxe_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int XFER_CYC   = 300,
  parameter int PROG_CYC   = 400,
  parameter int PA_W       = 10,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int MAXC_A    = (XFER_CYC > PROG_CYC) ? XFER_CYC : PROG_CYC,
  localparam int MAXC      = (MAXC_A > PAGE_BYTES) ? MAXC_A : PAGE_BYTES,
  localparam int TMR_W     = $clog2(MAXC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [1:0]       op_i,
  input  logic             sel_i,
  input  logic [PA_W-1:0]  page_i,
  output logic             idle_o,
  output logic             sel_o,
  output logic [PA_W-1:0]  page_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             buf_we_o,
  output logic             main_we_o,
  output logic             cmp_en_o,
  output logic             cmp_clr_o,
  output logic             cmp_done_o
);

  pxe_st_e           st_q;
  pxe_op_e           op_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              sel_q;
  logic [PA_W-1:0]   page_q;
  logic              accept;
  logic              byte_act;
  logic              xfer_last;
  logic              prog_last;

  assign accept    = launch_i && (st_q == ST_IDLE) && (pxe_op_e'(op_i) != OP_NONE);
  assign xfer_last = (tmr_q == TMR_W'(XFER_CYC - 1));
  assign prog_last = (tmr_q == TMR_W'(PROG_CYC - 1));
  assign byte_act  = (tmr_q < TMR_W'(PAGE_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_NONE;
      tmr_q  <= '0;
      sel_q  <= 1'b0;
      page_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            op_q   <= pxe_op_e'(op_i);
            sel_q  <= sel_i;
            page_q <= page_i;
            tmr_q  <= '0;
            st_q   <= (pxe_op_e'(op_i) == OP_CMP) ? ST_CMP : ST_XFER;
          end
        end
        ST_XFER, ST_CMP: begin
          if (xfer_last) begin
            tmr_q <= '0;
            st_q  <= (st_q == ST_XFER && op_q == OP_REWR) ? ST_PROG : ST_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (prog_last) begin
            tmr_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (st_q == ST_IDLE);
  assign sel_o      = sel_q;
  assign page_o     = page_q;
  assign idx_o      = tmr_q[IDX_W-1:0];
  assign buf_we_o   = (st_q == ST_XFER) && byte_act;
  assign main_we_o  = (st_q == ST_PROG) && byte_act;
  assign cmp_en_o   = (st_q == ST_CMP) && byte_act;
  assign cmp_clr_o  = accept;
  assign cmp_done_o = (st_q == ST_CMP) && xfer_last;

endmodule

// File: rtl/pxe_store.sv
module pxe_store
  import pxe_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 264,
  parameter int PA_W       = 10,
  parameter int NBUF       = 2,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int WORDS     = PAGES * PAGE_BYTES,
  localparam int ADDR_W    = $clog2(WORDS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PA_W-1:0]  page_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             sel_i,
  input  logic             buf_we_i,
  input  logic             main_we_i,
  input  logic             peek_sel_i,
  input  logic [IDX_W-1:0] peek_idx_i,
  output logic [7:0]       main_rd_o,
  output logic [7:0]       buf_rd_o,
  output logic [7:0]       peek_data_o
);

  logic [7:0]        main_mem [WORDS];
  logic [ADDR_W-1:0] addr;
  logic [7:0]        buf_rd  [NBUF];
  logic [7:0]        peek_rd [NBUF];

  // page address wraps on the array size
  assign addr = ADDR_W'(page_i % PA_W'(PAGES)) * ADDR_W'(PAGE_BYTES) + ADDR_W'(idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < WORDS; a++)
        main_mem[a] <= pxe_pattern(a / PAGE_BYTES, a % PAGE_BYTES, PAGE_BYTES);
    end else if (main_we_i) begin
      main_mem[addr] <= buf_rd_o;
    end
  end

  assign main_rd_o = main_mem[addr];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic [7:0] bmem [PAGE_BYTES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < PAGE_BYTES; k++) bmem[k] <= 8'h00;
      end else if (buf_we_i && (sel_i == 1'(g))) begin
        bmem[idx_i] <= main_rd_o;
      end
    end
    assign buf_rd[g]  = bmem[idx_i];
    assign peek_rd[g] = bmem[peek_idx_i];
  end

  assign buf_rd_o    = buf_rd[sel_i];
  assign peek_data_o = peek_rd[peek_sel_i];

endmodule

// File: rtl/pxe_cmp.sv
module pxe_cmp (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       done_i,
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  output logic       flag_o
);

  logic mism_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mism_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (clr_i) mism_q <= 1'b0;
      else if (en_i && !mism_q && (a_i != b_i)) mism_q <= 1'b1; // scan halts on first miss
      if (done_i) flag_q <= mism_q;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/page_xfer_engine.sv
module page_xfer_engine
  import pxe_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 264,
  parameter int XFER_CYC   = 300,
  parameter int PROG_CYC   = 400,
  localparam int PA_W      = 10,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [1:0]       op_i,
  input  logic             buf_sel_i,
  input  logic [PA_W-1:0]  page_i,
  input  logic             peek_sel_i,
  input  logic [IDX_W-1:0] peek_idx_i,
  output logic [7:0]       peek_data_o,
  output logic [7:0]       status_o
);

  logic             idle;
  logic             sel;
  logic [PA_W-1:0]  page;
  logic [IDX_W-1:0] idx;
  logic             buf_we;
  logic             main_we;
  logic             cmp_en;
  logic             cmp_clr;
  logic             cmp_done;
  logic [7:0]       main_rd;
  logic [7:0]       buf_rd;
  logic             cmp_flag;

  pxe_seq #(
    .PAGE_BYTES(PAGE_BYTES), .XFER_CYC(XFER_CYC), .PROG_CYC(PROG_CYC), .PA_W(PA_W)
  ) u_seq (
    .clk_i, .rst_ni, .launch_i, .op_i,
    .sel_i(buf_sel_i), .page_i,
    .idle_o(idle), .sel_o(sel), .page_o(page), .idx_o(idx),
    .buf_we_o(buf_we), .main_we_o(main_we), .cmp_en_o(cmp_en),
    .cmp_clr_o(cmp_clr), .cmp_done_o(cmp_done)
  );

  pxe_store #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .PA_W(PA_W), .NBUF(2)
  ) u_store (
    .clk_i, .rst_ni, .page_i(page), .idx_i(idx), .sel_i(sel),
    .buf_we_i(buf_we), .main_we_i(main_we),
    .peek_sel_i, .peek_idx_i,
    .main_rd_o(main_rd), .buf_rd_o(buf_rd), .peek_data_o
  );

  pxe_cmp u_cmp (
    .clk_i, .rst_ni, .clr_i(cmp_clr), .en_i(cmp_en), .done_i(cmp_done),
    .a_i(main_rd), .b_i(buf_rd), .flag_o(cmp_flag)
  );

  assign status_o = {idle, cmp_flag, 6'b0};

endmodule

// File: rtl/pxe_chk.sv
module pxe_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       launch_i,
  input logic [1:0] op_i,
  input logic [7:0] status_o,
  input logic       buf_we,
  input logic       main_we,
  input logic       cmp_en
);

  // R3
  a_r3_launch_goes_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && status_o[7] && op_i != 2'b11 |=> !status_o[7]);

  // R8
  a_r8_noop_stays_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && status_o[7] && op_i == 2'b11 |=> status_o[7]);

  // R5
  a_r5_flag_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[7] |=> (status_o[7] || $stable(status_o[6])));

  // R5
  a_r5_flag_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] |=> $stable(status_o[6]));

  // R2
  a_r2_one_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({buf_we, main_we, cmp_en}));

  // R2
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] |-> !(buf_we || main_we || cmp_en));

  // R6
  a_r6_prog_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_we |-> !status_o[7]);

endmodule

bind page_xfer_engine pxe_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch_i), .op_i(op_i),
  .status_o(status_o), .buf_we(buf_we), .main_we(main_we), .cmp_en(cmp_en)
);

// File: tb/tb_page_xfer_engine.sv
`timescale 1ns/1ps
module tb_page_xfer_engine;

  localparam int PAGES = 4;
  localparam int PB    = 264;
  localparam int XC    = 300;
  localparam int PC    = 400;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       launch_i = 1'b0;
  logic [1:0] op_i = 2'b11;
  logic       buf_sel_i = 1'b0;
  logic [9:0] page_i = '0;
  logic       peek_sel_i = 1'b0;
  logic [8:0] peek_idx_i = '0;
  logic [7:0] peek_data_o;
  logic [7:0] status_o;

  int total = 0;
  int bad = 0;
  int held [2];   // page held per buffer, -1 = cleared

  always #5 clk_i = ~clk_i;

  page_xfer_engine #(.PAGES(PAGES), .PAGE_BYTES(PB), .XFER_CYC(XC), .PROG_CYC(PC)) dut (
    .clk_i, .rst_ni, .launch_i, .op_i, .buf_sel_i, .page_i,
    .peek_sel_i, .peek_idx_i, .peek_data_o, .status_o
  );

  function automatic logic [7:0] pat(int pg, int ix);
    logic [7:0] v;
    if (pg < 0) return 8'h00;
    v = 8'(ix);
    if (pg % 2 == 1) v = v ^ 8'hA5;
    if (pg % 4 == 3 && ix == PB - 1) v = v ^ 8'h01;
    return v;
  endfunction

  function automatic logic differs(int pa, int pbb);
    for (int i = 0; i < PB; i++) if (pat(pa, i) != pat(pbb, i)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_buf(input int s, input string tag);
    int errs = 0;
    int first_a = 0;
    int first_e = 0;
    @(negedge clk_i);
    peek_sel_i = 1'(s);
    for (int i = 0; i < PB; i++) begin
      peek_idx_i = 9'(i);
      #0.1;
      if (peek_data_o != pat(held[s], i)) begin
        if (errs == 0) begin first_a = peek_data_o; first_e = pat(held[s], i); end
        errs++;
      end
    end
    check(errs == 0, tag, first_a, first_e);
  endtask

  // launch, optionally pulse a second launch mid-run, return busy length
  task automatic run_op(input logic [1:0] op, input int s, input int pg,
                        input int mid_at, input int mid_flag_exp,
                        input logic inject, output int cyc);
    int n = 0;
    @(negedge clk_i);
    op_i = op; buf_sel_i = 1'(s); page_i = 10'(pg); launch_i = 1'b1;
    @(negedge clk_i);
    launch_i = 1'b0;
    while (!status_o[7] && n < 5000) begin
      n++;
      if (n == mid_at && mid_flag_exp >= 0)
        check(status_o[6] == 1'(mid_flag_exp), "R5 flag held while busy",
              status_o[6], mid_flag_exp);
      if (n == 20 && inject) begin
        op_i = 2'b00; buf_sel_i = ~buf_sel_i; page_i = 10'd3; launch_i = 1'b1;
      end
      @(negedge clk_i);
      launch_i = 1'b0;
    end
    cyc = n;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c;
    logic expf;
    held[0] = -1; held[1] = -1;
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    check(status_o == 8'h80, "R1 reset status", status_o, 8'h80);
    chk_buf(0, "R1 buffer0 cleared");
    chk_buf(1, "R1 buffer1 cleared");

    // transfer sweep: every page into every buffer, other buffer checked too
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < PAGES; p++) begin
        run_op(2'b00, s, p, 0, -1, 1'b0, c);
        held[s] = p;
        check(c == XC, "R3 transfer busy length", c, XC);
        chk_buf(s, "R2 transfer target");
        chk_buf(1 - s, "R2 other buffer untouched");
      end
    end

    // set up buffer0 = page0, buffer1 = page1, then compare sweep
    run_op(2'b00, 0, 0, 0, -1, 1'b0, c); held[0] = 0;
    run_op(2'b00, 1, 1, 0, -1, 1'b0, c); held[1] = 1;
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < PAGES; p++) begin
        run_op(2'b01, s, p, 0, -1, 1'b0, c);
        expf = differs(held[s], p);
        check(c == XC, "R4 compare busy length", c, XC);
        check(status_o[6] == expf, "R4 compare result", status_o[6], expf);
      end
    end

    // buffer1 (page1) vs page3: mismatch in last byte only
    run_op(2'b01, 1, 3, 0, -1, 1'b0, c);
    check(status_o[6] == 1'b1, "R4 last byte mismatch", status_o[6], 1);
    // match compare: flag must hold 1 while busy, then drop
    run_op(2'b01, 0, 2, 150, 1, 1'b0, c);
    check(status_o[6] == 1'b0, "R4 match after miss", status_o[6], 0);
    // early mismatch still full length; then flag survives a transfer
    run_op(2'b01, 0, 1, 0, -1, 1'b0, c);
    check(c == XC, "R4 early miss busy length", c, XC);
    run_op(2'b00, 0, 0, 100, 1, 1'b0, c);
    check(status_o[6] == 1'b1, "R5 flag kept across transfer", status_o[6], 1);

    // address wrap
    run_op(2'b00, 0, 1021, 0, -1, 1'b0, c); held[0] = 1021 % PAGES;
    chk_buf(0, "R7 page address wraps");
    run_op(2'b01, 0, 5, 0, -1, 1'b0, c);
    check(status_o[6] == 1'b0, "R7 wrapped compare", status_o[6], 0);

    // auto rewrite
    run_op(2'b10, 1, 2, 500, 0, 1'b0, c); held[1] = 2;
    check(c == XC + PC, "R6 rewrite busy length", c, XC + PC);
    chk_buf(1, "R6 rewrite buffer");
    run_op(2'b01, 1, 2, 0, -1, 1'b0, c);
    check(status_o[6] == 1'b0, "R6 page intact after rewrite", status_o[6], 0);
    run_op(2'b01, 1, 0, 0, -1, 1'b0, c);
    check(status_o[6] == 1'b0, "R6 equal page compare", status_o[6], 0);

    // launch while busy is dropped
    run_op(2'b00, 0, 0, 0, -1, 1'b1, c); held[0] = 0;
    check(c == XC, "R8 busy launch ignored length", c, XC);
    chk_buf(1, "R8 busy launch left buffer1");
    chk_buf(0, "R8 first op completed");

    // op 11 is a no-op
    @(negedge clk_i);
    op_i = 2'b11; buf_sel_i = 1'b1; page_i = 10'd3; launch_i = 1'b1;
    @(negedge clk_i);
    launch_i = 1'b0;
    check(status_o == 8'h80, "R8 no-op stays ready", status_o, 8'h80);
    repeat (5) @(negedge clk_i);
    check(status_o == 8'h80, "R8 no-op still ready", status_o, 8'h80);
    chk_buf(1, "R8 no-op left buffer1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule